// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a binary down counter, eight bits wide by default. While counting is enabled it steps down by one on every rising clock edge. It can be preset from a parallel jam word in two ways: at once, through an asynchronous load strobe, or on the next clock edge, through a synchronous load strobe. An asynchronous clear forces the count to its all-ones maximum rather than to zero.

An active-low terminal-count flag marks the zero state while counting is enabled. The enable reaches that flag through a combinational path, so stages can be chained: one stage's flag drives the next stage's enable to build a longer counter. If the flag is fed back to the synchronous load strobe, the counter divides the clock by N+1, where N is the jam word.

All controls are active low. The count is brought out as a port so that it can be observed.

Top module: `preset_down_counter`

## Requirements
- R1: While `clr_n` is low, the count is forced to all ones (255 at the default width) at once, without waiting for a clock. Every other input is ignored while it is low, and clock edges leave the count at 255.
- R2: When `clr_n` is high and `aload_n` goes low, `jam` is written to the count at once, without a clock. While `aload_n` stays low, clock edges keep the count at `jam` whatever the values of `sload_n` and `en_n`. `jam` must stay stable while `aload_n` is low.
- R3: When both asynchronous controls are high and `sload_n` is low, the next rising edge loads `jam`. This happens whether `en_n` is high or low, and the load takes priority over counting.
- R4: When `clr_n`, `aload_n` and `sload_n` are all high and `en_n` is low, each rising edge lowers the count by exactly one.
- R5: When `en_n` is high and no load or clear is active, the count holds its value across clock edges.
- R6: `tc_n` is low exactly when the count is zero and `en_n` is low, and it is high in every other case. In a count sequence it therefore stays low for one full clock period.
- R7: A change on `en_n` reaches `tc_n` with no clock edge in between.
- R8: When counting is enabled, an edge at count zero wraps the count to 255, so a free-running count repeats every 256 edges.
- R9: `jam` is read as one unsigned binary word, with bit 7 as the most significant bit. Loading 8'h80 gives a count of 128, and the next enabled edge gives 127.
- R10: Two stages form a 16-bit down counter when the low stage's `tc_n` drives the high stage's `en_n`. The high stage's `tc_n` is then low only when the 16-bit value is zero.
- R11: When `tc_n` is tied to `sload_n`, with `en_n` low and `jam` equal to N, `tc_n` pulses low once every N+1 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous actions happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear to all ones, active low, highest priority |
| aload_n | input | 1 | Asynchronous preset from `jam`, active low |
| sload_n | input | 1 | Synchronous preset from `jam` on the next edge, active low |
| en_n | input | 1 | Count enable, active low; also gates the terminal flag |
| jam | input | W | Parallel preset word, MSB first |
| count | output | W | Present count value |
| tc_n | output | 1 | Terminal count, active low: zero reached while enabled |

## Verification
Synchronous results (decrement, hold, synchronous load, wrap) appear one edge after the inputs that cause them. The bench drives inputs on the falling edge. At the rising edge that acts on them, it queues the value a reference model predicts, and it compares that value a quarter period later. Asynchronous results (clear and asynchronous load) and the enable-to-flag path act in the same time step as the stimulus. These are checked 1 ns after the input changes, between clock edges. The cascade and divider checks sample both stages at the same quarter-period point after each edge, and they measure the spacing of the flag pulses in edges.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
// pdc_pkg: shared types for the preset down counter.
// Assumes: nothing; holds only the synchronous step encoding.
package pdc_pkg;
    // Action taken by the counter register on a rising clock edge.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_JAM  = 2'd2
    } step_t;
endpackage

// File: rtl/pdc_step.sv
`timescale 1ns/1ps
// pdc_step: chooses the synchronous action from the active-low controls.
// Assumes: the asynchronous controls are handled in the register itself,
// so only the synchronous load and the enable are ranked here.
module pdc_step
    import pdc_pkg::*;
(
    input  logic  sload_n,
    input  logic  en_n,
    output step_t step
);
    // Rank: synchronous load beats counting, counting beats holding.
    always_comb begin
        if (!sload_n)   step = STEP_JAM;
        else if (!en_n) step = STEP_DEC;
        else            step = STEP_HOLD;
    end
endmodule

// File: rtl/pdc_next.sv
`timescale 1ns/1ps
// pdc_next: forms the value the register takes on the next edge.
// Assumes: modulo-2^W arithmetic, so zero minus one wraps to all ones.
module pdc_next
    import pdc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] jam,
    input  step_t        step,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    // Select the load word, the decremented value or the present value.
    always_comb begin
        unique case (step)
            STEP_JAM: nxt = jam;
            STEP_DEC: nxt = cur - ONE;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/pdc_reg.sv
`timescale 1ns/1ps
// pdc_reg: count register with asynchronous clear-to-max and asynchronous load.
// Assumes: jam is stable while aload_n is low; clr_n outranks aload_n.
module pdc_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         aload_n,
    input  logic [W-1:0] jam,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Clear to all ones, then async preset, else take the synchronous next value.
    always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
        if (!clr_n)        q <= MAXV;
        else if (!aload_n) q <= jam;
        else               q <= nxt;
    end
endmodule

// File: rtl/pdc_term.sv
`timescale 1ns/1ps
// pdc_term: active-low terminal-count flag.
// Assumes: en_n reaches the flag combinationally so that stages can be chained.
module pdc_term #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         en_n,
    output logic         tc_n
);
    // Flag goes low only at zero while the enable is active.
    always_comb tc_n = ~((cur == '0) & ~en_n);
endmodule

// File: rtl/preset_down_counter.sv
`timescale 1ns/1ps
// preset_down_counter: presettable binary down counter with a chainable terminal flag.
// Assumes: all controls active low; the ranking is clear, async load,
// sync load, then count or hold.
module preset_down_counter
    import pdc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         aload_n,
    input  logic         sload_n,
    input  logic         en_n,
    input  logic [W-1:0] jam,
    output logic [W-1:0] count,
    output logic         tc_n
);
    step_t        step;
    logic [W-1:0] nxt;
    logic [W-1:0] cur;

    pdc_step u_step (
        .sload_n (sload_n),
        .en_n    (en_n),
        .step    (step)
    );

    pdc_next #(.W(W)) u_next (
        .cur  (cur),
        .jam  (jam),
        .step (step),
        .nxt  (nxt)
    );

    pdc_reg #(.W(W)) u_reg (
        .clk     (clk),
        .clr_n   (clr_n),
        .aload_n (aload_n),
        .jam     (jam),
        .nxt     (nxt),
        .q       (cur)
    );

    pdc_term #(.W(W)) u_term (
        .cur  (cur),
        .en_n (en_n),
        .tc_n (tc_n)
    );

    // Expose the register value.
    always_comb count = cur;
endmodule

// File: rtl/pdc_checker.sv
`timescale 1ns/1ps
// pdc_checker: temporal properties of preset_down_counter, bound to every instance.
// Assumes: jam is held stable while aload_n is low.
module pdc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic         aload_n,
    input logic         sload_n,
    input logic         en_n,
    input logic [W-1:0] jam,
    input logic [W-1:0] count,
    input logic         tc_n
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    a_r1_clear_max: assert property (@(posedge clk)
        !clr_n |-> count == MAXV);

    a_r2_async_load: assert property (@(posedge clk)
        (clr_n && !aload_n) |-> count == jam);

    a_r3_sync_load: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        !sload_n |=> count == $past(jam));

    a_r4_decrement: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (sload_n && !en_n) |=> count == $past(count) - ONE);

    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (sload_n && en_n) |=> count == $past(count));

    a_r6_flag_low: assert property (@(posedge clk) disable iff (!clr_n)
        (count == '0 && !en_n) |-> !tc_n);

    a_r6_flag_high: assert property (@(posedge clk) disable iff (!clr_n)
        (count != '0 || en_n) |-> tc_n);
endmodule

bind preset_down_counter pdc_checker #(.W(W)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .aload_n (aload_n),
    .sload_n (sload_n),
    .en_n    (en_n),
    .jam     (jam),
    .count   (count),
    .tc_n    (tc_n)
);

// File: tb/sim_preset_down_counter.sv
`timescale 1ns/1ps
// sim_preset_down_counter: scoreboard bench with a reference model, a two-stage
// cascade and a divide-by-(N+1) loop.
module sim_preset_down_counter;
    localparam int CLK_T = 10;
    localparam int W = 8;
    localparam logic [7:0] MAXV = 8'hFF;

    logic clk = 1'b0;
    always #(CLK_T/2) clk = ~clk;

    // Main unit.
    logic clr_n, aload_n, sload_n, en_n;
    logic [7:0] jam;
    logic [7:0] count;
    logic tc_n;

    preset_down_counter #(.W(W)) u0 (
        .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
        .en_n(en_n), .jam(jam), .count(count), .tc_n(tc_n)
    );

    // Two-stage cascade.
    logic k_clr_n, k_al_n;
    logic [7:0] k_lo, k_hi;
    logic k_lo_tc, k_hi_tc;

    preset_down_counter #(.W(W)) u_lo (
        .clk(clk), .clr_n(k_clr_n), .aload_n(k_al_n), .sload_n(1'b1),
        .en_n(1'b0), .jam(8'h03), .count(k_lo), .tc_n(k_lo_tc)
    );
    preset_down_counter #(.W(W)) u_hi (
        .clk(clk), .clr_n(k_clr_n), .aload_n(k_al_n), .sload_n(1'b1),
        .en_n(k_lo_tc), .jam(8'h01), .count(k_hi), .tc_n(k_hi_tc)
    );

    // Divider: the flag reloads the counter.
    logic d_clr_n, d_al_n;
    logic [7:0] d_count;
    logic d_tc;

    preset_down_counter #(.W(W)) u_div (
        .clk(clk), .clr_n(d_clr_n), .aload_n(d_al_n), .sload_n(d_tc),
        .en_n(1'b0), .jam(8'h05), .count(d_count), .tc_n(d_tc)
    );

    typedef struct {
        string      req;
        logic [7:0] cnt;
        logic       tc;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] m;

    task automatic check(input string req, input int act_c, input int exp_c,
                         input int act_t, input int exp_t);
        n_chk++;
        if (act_c != exp_c || act_t != exp_t) begin
            n_fail++;
            $display("FAIL %s: count=%0d tc=%0d, expected count=%0d tc=%0d",
                     req, act_c, act_t, exp_c, exp_t);
        end
    endtask

    // Driver: change inputs on the falling edge and model the async effects.
    task automatic drive(input logic c, input logic a, input logic s,
                         input logic e, input logic [7:0] j);
        @(negedge clk);
        jam = j;
        sload_n = s;
        en_n = e;
        aload_n = a;
        clr_n = c;
        if (!c)      m = MAXV;
        else if (!a) m = j;
    endtask

    // Compare an async or combinational result just after the stimulus.
    task automatic now_chk(input string req);
        #1;
        check(req, count, m, tc_n, !(m == 8'h00 && !en_n));
    endtask

    // At the rising edge, step the model and queue the expected result.
    task automatic cyc(input string req);
        @(posedge clk);
        if (!clr_n)        m = MAXV;
        else if (!aload_n) m = jam;
        else if (!sload_n) m = jam;
        else if (!en_n)    m = m - 8'h01;
        sb.push_back('{req, m, !(m == 8'h00 && !en_n)});
    endtask

    // Monitor: pop and compare a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_T/4);
        if (sb.size() != 0) begin
            cur = sb.pop_front();
            check(cur.req, count, cur.cnt, tc_n, cur.tc);
        end
    end

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int gap;
        int pulses;
        bit first;
        logic [15:0] e16;
        clr_n = 1'b1; aload_n = 1'b1; sload_n = 1'b1; en_n = 1'b0; jam = 8'h00;
        k_clr_n = 1'b1; k_al_n = 1'b1; d_clr_n = 1'b1; d_al_n = 1'b1;
        m = MAXV;
        #1;
        clr_n = 1'b0; k_clr_n = 1'b0; d_clr_n = 1'b0;

        // R1: reset state and clear holding across an edge.
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00); now_chk("R1");
        cyc("R1");
        // R4: plain decrement.
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        repeat (3) cyc("R4");
        // R2: immediate async load, then it beats sync load and count.
        drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h03); now_chk("R2");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h03); cyc("R2");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h03); cyc("R4");
        // R1: clear beats async load.
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h5A); now_chk("R1");
        cyc("R1");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h5A);
        // R3: sync load with enable off, then sync load beats count.
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h42); cyc("R3");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h10); cyc("R3");
        // R5: hold.
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h77);
        repeat (4) cyc("R5");
        // R6: count into zero.
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h02); cyc("R6");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h02); cyc("R6"); cyc("R6");
        // R7: enable reaches the flag without a clock.
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h02); now_chk("R7");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h02); now_chk("R7");
        // R8: wrap and a full 256-edge cycle.
        cyc("R8");
        repeat (255) cyc("R8");
        cyc("R8");
        // R9: bit order of the jam word.
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h80); cyc("R9");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h80); cyc("R9");
        @(negedge clk);

        // R10: 16-bit cascade preset to 0x0103, run through zero.
        @(negedge clk);
        k_clr_n = 1'b1; k_al_n = 1'b0;
        #1 k_al_n = 1'b1;
        e16 = 16'h0103;
        #1 check("R10", {k_hi, k_lo}, e16, k_hi_tc, 1);
        repeat (300) begin
            @(posedge clk);
            #(CLK_T/4);
            e16 = e16 - 16'h0001;
            check("R10", {k_hi, k_lo}, e16, k_hi_tc, (e16 == 16'h0000) ? 0 : 1);
        end

        // R11: divide by N+1 with N = 5.
        @(negedge clk);
        d_clr_n = 1'b1; d_al_n = 1'b0;
        #1 d_al_n = 1'b1;
        gap = 0; pulses = 0; first = 1'b1;
        repeat (40) begin
            @(posedge clk);
            #(CLK_T/4);
            gap++;
            if (!d_tc) begin
                if (!first) check("R11", gap, 6, 0, 0);
                first = 1'b0;
                gap = 0;
                pulses++;
            end
        end
        check("R11", pulses, 6, 0, 0);

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule